// File: doc/BRIEF.md
# Condition flag manipulation unit

This execution unit holds the four condition flags (negative, zero, carry, overflow) and executes three instructions that write them directly. The rotate form rotates a 64-bit source register right and copies its four low bits into the flags. A per-flag mask chooses which flags are written. The evaluate form checks the sign and signed overflow of the low byte or low halfword of a source register. The carry-invert form toggles the carry flag.

The unit receives a 32-bit instruction word with a valid strobe and a feature-enable input. It drives a register index to a register file and receives the 64-bit operand in the same cycle. Flag updates take effect at the next clock edge. Any word the unit does not accept raises an undefined-instruction output in the cycle the word is presented, and the flags do not change. Instruction fetch, the rest of the register file and exception handling belong to the surrounding core.

Top module: `flag_manip_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flags are cleared to 0000 (flags bit 3 = N, 2 = Z, 1 = C, 0 = V). `undef` is low whenever `instr_valid` is low.
- R2: A rotate word is accepted only when all of these hold: bits [31:21] = 10111010000, bits [14:10] = 00001 and bit 4 = 0. Bits [20:15] give the rotate amount, bits [9:5] the register index and bits [3:0] the mask.
- R3: For a rotate word, the 64-bit operand is rotated right by the amount, with wraparound (amount 63 equals rotate left by 1). Result bit 3 goes to N, bit 2 to Z, bit 1 to C and bit 0 to V.
- R4: For a rotate word, a flag is written only when its mask bit is set (mask bit 3 = N, 2 = Z, 1 = C, 0 = V). All other flags keep their values.
- R5: An evaluate word is accepted only when all of these hold: bits [31:21] = 00111010000, bits [20:15] = 0, bits [13:10] = 0010 and bits [4:0] = 01101. Bit 14 selects the size and bits [9:5] give the register index.
- R6: When bit 14 is 0 (byte form), N = operand bit 7, Z = 1 when operand bits [7:0] are all zero, and V = bit 8 XOR bit 7. C is unchanged.
- R7: When bit 14 is 1 (halfword form), N = operand bit 15, Z = 1 when operand bits [15:0] are all zero, and V = bit 16 XOR bit 15. C is unchanged.
- R8: The carry-invert word is exactly 32'hD500401F (selector fields op1, op2 and CRm all zero). It toggles C and leaves N, Z and V unchanged.
- R9: When `feat_en` is low, all three forms raise `undef` and the flags do not change.
- R10: Any valid word that is not accepted raises `undef` in the same cycle, and the flags do not change.
- R11: `rd_idx` always shows instruction bits [9:5]. `rd_is_sp` is high only when the word has the rotate form and index 31, so the register file supplies the stack pointer. For an evaluate word with index 31, the operand is taken as zero and `rd_data` is ignored.
- R12: An accepted word changes the flags at the clock edge that samples it. When `instr_valid` is low, the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| feat_en | input | 1 | Enables the flag-manipulation instructions |
| rd_idx | output | 5 | Source register index, bits [9:5] of the word |
| rd_is_sp | output | 1 | Index 31 means the stack pointer (rotate form) |
| rd_data | input | 64 | Source operand, valid in the same cycle as `rd_idx` |
| flags | output | 4 | Condition flags N, Z, C, V (bits 3 to 0) |
| undef | output | 1 | Rejected instruction, high in the cycle it is presented |

## Verification
The assertions assume that `instr_word`, `feat_en` and `rd_data` are stable from the drive point until the sampling clock edge. They also assume that `rd_data` already holds the register selected by the current `rd_idx` in that same cycle. The bench drives every input on the falling edge. It sets the operand from each vector together with the word, so no operand ever lags its index. Reset is applied only while `instr_valid` is low, which keeps the hold and reset properties from overlapping.

// File: rtl/flagm_pkg.sv
// Shared encodings and types for the condition flag manipulation unit.
// Assumes a 32-bit instruction word; the flag order N, Z, C, V is fixed.
package flagm_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ROT  = 2'd1,
        OP_EVAL = 2'd2,
        OP_CINV = 2'd3
    } flag_op_e;

    localparam logic [10:0] ROT_HI    = 11'b10111010000;
    localparam logic [4:0]  ROT_MID   = 5'b00001;
    localparam logic [10:0] EVAL_HI   = 11'b00111010000;
    localparam logic [3:0]  EVAL_MID  = 4'b0010;
    localparam logic [4:0]  EVAL_LOW  = 5'b01101;
    localparam logic [31:0] CINV_WORD = 32'hD500401F;

endpackage

// File: rtl/flagm_decode.sv
// Decoder: matches the three accepted encodings exactly and reports the
// selected operation, the register index and the undefined pulse.
// Assumes the word and feat_en are stable for the whole cycle.
module flagm_decode
    import flagm_pkg::*;
#(
    parameter int IW    = 32,
    parameter int IDX_W = 5
) (
    input  logic             valid_i,
    input  logic [IW-1:0]    word_i,
    input  logic             feat_i,
    output flag_op_e         op_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             sp_sel_o,
    output logic             undef_o
);

    localparam logic [IDX_W-1:0] SP_IDX = '1;

    logic rot_shape;
    logic eval_shape;
    logic cinv_shape;

    // Exact shape match of each form's fixed fields.
    always_comb begin
        rot_shape  = (word_i[31:21] == ROT_HI) && (word_i[14:10] == ROT_MID) && !word_i[4];
        eval_shape = (word_i[31:21] == EVAL_HI) && (word_i[20:15] == 6'd0) &&
                     (word_i[13:10] == EVAL_MID) && (word_i[4:0] == EVAL_LOW);
        cinv_shape = (word_i == CINV_WORD);
    end

    // Operation select, gated by valid and the feature enable.
    always_comb begin
        op_o = OP_NONE;
        if (valid_i && feat_i) begin
            if (rot_shape)       op_o = OP_ROT;
            else if (eval_shape) op_o = OP_EVAL;
            else if (cinv_shape) op_o = OP_CINV;
        end
    end

    // Register port and rejection pulse.
    always_comb begin
        idx_o    = word_i[9:5];
        sp_sel_o = rot_shape && (word_i[9:5] == SP_IDX);
        undef_o  = valid_i && (op_o == OP_NONE);
    end

endmodule

// File: rtl/flagm_exec.sv
// Datapath: computes per-flag write enables and new values for the
// selected operation. Assumes operand data matches the presented index.
module flagm_exec
    import flagm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IW    = 32,
    parameter int IDX_W = 5
) (
    input  flag_op_e       op_i,
    input  logic [IW-1:0]  word_i,
    input  logic [XLEN-1:0] operand_i,
    input  logic           cur_c_i,
    output logic [3:0]     wr_en_o,
    output nzcv_t          wr_val_o
);

    localparam int ROT_W = $clog2(XLEN);
    localparam logic [IDX_W-1:0] ZERO_IDX = '1;

    logic [2*XLEN-1:0] dbl;
    logic [XLEN-1:0]   rotated;
    logic [XLEN-1:0]   eval_src;
    logic [ROT_W-1:0]  amt;
    nzcv_t             rot_val;
    nzcv_t             eval_val;

    // Rotate right with wraparound via a doubled operand.
    always_comb begin
        amt     = word_i[15 +: ROT_W];
        dbl     = {operand_i, operand_i} >> amt;
        rotated = dbl[XLEN-1:0];
        rot_val = nzcv_t'(rotated[3:0]);
    end

    // Byte or halfword sign, zero and overflow tests; index 31 reads zero.
    always_comb begin
        eval_src   = (word_i[9:5] == ZERO_IDX) ? '0 : operand_i;
        eval_val.c = cur_c_i;
        if (word_i[14]) begin
            eval_val.n = eval_src[15];
            eval_val.z = (eval_src[15:0] == 16'd0);
            eval_val.v = eval_src[16] ^ eval_src[15];
        end else begin
            eval_val.n = eval_src[7];
            eval_val.z = (eval_src[7:0] == 8'd0);
            eval_val.v = eval_src[8] ^ eval_src[7];
        end
    end

    // Per-operation write enables and values.
    always_comb begin
        wr_en_o  = 4'b0000;
        wr_val_o = rot_val;
        unique case (op_i)
            OP_ROT: begin
                wr_en_o  = word_i[3:0];
                wr_val_o = rot_val;
            end
            OP_EVAL: begin
                wr_en_o  = 4'b1101;
                wr_val_o = eval_val;
            end
            OP_CINV: begin
                wr_en_o  = 4'b0010;
                wr_val_o = '{n: 1'b0, z: 1'b0, c: !cur_c_i, v: 1'b0};
            end
            default: wr_en_o = 4'b0000;
        endcase
    end

endmodule

// File: rtl/flagm_flagreg.sv
// Condition flag storage: each flag loads on its own enable.
// Synchronous active-low reset clears all flags.
module flagm_flagreg
    import flagm_pkg::*;
#(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] wr_en_i,
    input  logic [NFLAG-1:0] wr_val_i,
    output logic [NFLAG-1:0] flags_o
);

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        // One flag bit: clear on reset, load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_o[k] <= 1'b0;
            else if (wr_en_i[k]) flags_o[k] <= wr_val_i[k];
        end
    end

    AST_MASKED_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i == '0) |=> $stable(flags_o)); // R4

endmodule

// File: rtl/flag_manip_unit.sv
// Top of the condition flag manipulation unit: decoder, datapath and
// flag register. Assumes rd_data answers rd_idx in the same cycle.
module flag_manip_unit
    import flagm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IW    = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [IW-1:0]    instr_word,
    input  logic             feat_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_is_sp,
    input  logic [XLEN-1:0]  rd_data,
    output logic [3:0]       flags,
    output logic             undef
);

    flag_op_e   op;
    logic [3:0] wr_en;
    nzcv_t      wr_val;
    nzcv_t      cur;

    // Current flags viewed as the named struct.
    always_comb cur = nzcv_t'(flags);

    flagm_decode #(.IW(IW), .IDX_W(IDX_W)) u_decode (
        .valid_i  (instr_valid),
        .word_i   (instr_word),
        .feat_i   (feat_en),
        .op_o     (op),
        .idx_o    (rd_idx),
        .sp_sel_o (rd_is_sp),
        .undef_o  (undef)
    );

    flagm_exec #(.XLEN(XLEN), .IW(IW), .IDX_W(IDX_W)) u_exec (
        .op_i      (op),
        .word_i    (instr_word),
        .operand_i (rd_data),
        .cur_c_i   (cur.c),
        .wr_en_o   (wr_en),
        .wr_val_o  (wr_val)
    );

    flagm_flagreg #(.NFLAG(4)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_val_i (wr_val),
        .flags_o  (flags)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (flags == 4'b0000)); // R1
    AST_UNDEF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> instr_valid); // R1
    AST_FEAT_OFF_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !feat_en) |-> undef); // R9
    AST_UNDEF_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        undef |=> $stable(flags)); // R10
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(flags)); // R12
    AST_CINV_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && feat_en && instr_word == CINV_WORD) |=>
        (flags == ($past(flags) ^ 4'b0010))); // R8
    AST_EVAL_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EVAL) |=> (flags[1] == $past(flags[1]))); // R6
    AST_SP_ONLY_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_is_sp |-> (instr_word[31:21] == ROT_HI && rd_idx == 5'd31)); // R11

endmodule

// File: tb/flag_manip_unit_tb.sv
`timescale 1ns/1ps
module flag_manip_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = 32'd0;
    logic        feat_en = 1'b1;
    logic [4:0]  rd_idx;
    logic        rd_is_sp;
    logic [63:0] rd_data = 64'd0;
    logic [3:0]  flags;
    logic        undef;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flag_manip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .feat_en(feat_en), .rd_idx(rd_idx),
        .rd_is_sp(rd_is_sp), .rd_data(rd_data), .flags(flags), .undef(undef)
    );

    // Vector: req[106:103] word[102:71] operand[70:7] feat[6] undef[5] sp[4] flags[3:0]
    localparam int NV = 22;
    localparam logic [106:0] VEC [NV] = '{
        {4'd3,  32'hBA00042F, 64'h000000000000000A, 1'b1, 1'b0, 1'b0, 4'b1010}, // R3 amount 0
        {4'd3,  32'hBA02044F, 64'h0000000000000050, 1'b1, 1'b0, 1'b0, 4'b0101}, // R3 amount 4
        {4'd3,  32'hBA1F846F, 64'h8000000000000005, 1'b1, 1'b0, 1'b0, 4'b1011}, // R3 wraparound 63
        {4'd4,  32'hBA000488, 64'h0000000000000000, 1'b1, 1'b0, 1'b0, 4'b0011}, // R4 N only
        {4'd4,  32'hBA000484, 64'h000000000000000F, 1'b1, 1'b0, 1'b0, 4'b0111}, // R4 Z only
        {4'd4,  32'hBA000480, 64'h000000000000000F, 1'b1, 1'b0, 1'b0, 4'b0111}, // R4 empty mask
        {4'd6,  32'h3A0008AD, 64'h0000000000000180, 1'b1, 1'b0, 1'b0, 4'b1010}, // R6 byte negative
        {4'd6,  32'h3A0008AD, 64'h0000000000000100, 1'b1, 1'b0, 1'b0, 4'b0111}, // R6 byte zero, overflow
        {4'd7,  32'h3A0048CD, 64'h0000000000008000, 1'b1, 1'b0, 1'b0, 4'b1011}, // R7 half negative
        {4'd7,  32'h3A0048CD, 64'h0000000000010000, 1'b1, 1'b0, 1'b0, 4'b0111}, // R7 half zero, overflow
        {4'd8,  32'hD500401F, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'b0101}, // R8 toggle C off
        {4'd8,  32'hD500401F, 64'h0000000000000000, 1'b1, 1'b0, 1'b0, 4'b0111}, // R8 toggle C on
        {4'd11, 32'h3A000BED, 64'hFFFFFFFFFFFFFF80, 1'b1, 1'b0, 1'b0, 4'b0110}, // R11 index 31 reads zero
        {4'd11, 32'hBA0007EF, 64'h0000000000000009, 1'b1, 1'b0, 1'b1, 4'b1001}, // R11 stack pointer select
        {4'd9,  32'hBA00042F, 64'h0000000000000006, 1'b0, 1'b1, 1'b0, 4'b1001}, // R9 rotate disabled
        {4'd9,  32'hD500401F, 64'h0000000000000000, 1'b0, 1'b1, 1'b0, 4'b1001}, // R9 invert disabled
        {4'd2,  32'hBA00043F, 64'h0000000000000006, 1'b1, 1'b1, 1'b0, 4'b1001}, // R2 bit 4 set
        {4'd2,  32'hBA00002F, 64'h0000000000000006, 1'b1, 1'b1, 1'b0, 4'b1001}, // R2 bits 14:10 wrong
        {4'd5,  32'h3A00880D, 64'h0000000000000000, 1'b1, 1'b1, 1'b0, 4'b1001}, // R5 bits 20:15 nonzero
        {4'd5,  32'h3A00080C, 64'h0000000000000000, 1'b1, 1'b1, 1'b0, 4'b1001}, // R5 low field wrong
        {4'd8,  32'hD500411F, 64'h0000000000000000, 1'b1, 1'b1, 1'b0, 4'b1001}, // R8 CRm nonzero
        {4'd10, 32'h00000000, 64'h0000000000000000, 1'b1, 1'b1, 1'b0, 4'b1001}  // R10 unrelated word
    };

    task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one word for one cycle, check the same-cycle and next-cycle outputs.
    task automatic apply(input int req, input logic [31:0] w, input logic [63:0] d,
                         input logic fe, input logic eu, input logic es, input logic [3:0] ef);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        rd_data     = d;
        feat_en     = fe;
        #2;
        chk(req, 64'(undef), 64'(eu), "undef");
        chk(req, 64'(rd_is_sp), 64'(es), "rd_is_sp");
        chk(11, 64'(rd_idx), 64'(w[9:5]), "rd_idx"); // R11
        @(negedge clk);
        instr_valid = 1'b0;
        feat_en     = 1'b1;
        #1;
        chk(req, 64'(flags), 64'(ef), "flags");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(1, 64'(flags), 64'h0, "reset flags");   // R1
        chk(1, 64'(undef), 64'h0, "reset undef");   // R1
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(int'(VEC[i][106:103]), VEC[i][102:71], VEC[i][70:7],
                  VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end

        // R12: an accepted word with valid low changes nothing.
        @(negedge clk);
        instr_word = 32'hD500401F;
        rd_data    = 64'hF;
        repeat (3) @(negedge clk);
        #1;
        chk(12, 64'(flags), 64'h9, "idle hold");
        chk(1, 64'(undef), 64'h0, "undef without valid");

        // R12: update visible right after the sampling edge, not before.
        @(negedge clk);
        instr_valid = 1'b1;
        #2;
        chk(12, 64'(flags), 64'h9, "before edge");
        @(posedge clk);
        #1;
        chk(12, 64'(flags), 64'hB, "after edge");
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        chk(10, 64'(undef), 64'h0, "undef pulse ends");

        // R1: reset in mid-run clears the flags.
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(1, 64'(flags), 64'h0, "mid-run reset");
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule